// File: doc/BRIEF.md
# Slave TDM Audio Serial Port

This block is the serial end of a multichannel audio codec link in which the codec is the timing master. The codec supplies the bit clock and an active-high frame pulse. A frame carries `NUM_CH` words of `WORD_W` bits, one word per channel, sent most significant bit first. The first data bit follows the frame pulse by exactly one bit period. The port has no clock or frame generator of its own. The bit clock, frame pulse and serial input are brought into the system clock domain through a synchronizer chain. The two edges of the bit clock are then detected there. The transmitter launches its bits on bit-clock rising edges, and the receiver samples on falling edges.

Received words appear right-justified in a wider parallel register, with the upper bits zero. A one-cycle request strobe accompanies each received word. Transmit words are written into a one-word holding register. A request strobe pulses when that holding register is moved into the shifter, which asks for the word of the next slot. Each direction raises a one-cycle event at every accepted frame start. A frame pulse that arrives in the middle of a frame is ignored, and it sets a sticky error flag. A transmit slot that finds no fresh word sends zeros and sets a sticky underrun flag. The receiver and the transmitter are each held idle until enabled, and the transmitter output stays low while it is idle.

Top module: `tdm_slave_port`

## Requirements
- R1: While `tx_en` is low, `dout` is 0 and `tx_frame` and `tx_req` do not pulse. While `rx_en` is low, `rx_req` and `rx_frame` do not pulse, and `rx_data` keeps its last value. All outputs are 0 after reset.
- R2: A frame starts when `fsync` is sampled high on a bit-clock falling edge after having been low on the previous falling edge. The receiver takes data bits on the following falling edges, most significant bit first, beginning one bit period after the frame pulse.
- R3: `rx_data` holds the last complete word in bits `WORD_W-1:0`, and bits above that are 0.
- R4: `rx_req` pulses for one system clock after each completed received word, which gives `NUM_CH` pulses per frame. The last word of a frame always produces a pulse.
- R5: `dout` carries each transmit word most significant bit first. Each bit changes after a bit-clock rising edge, and the first bit occupies the bit period after the frame pulse.
- R6: `tx_req` pulses for one system clock when a slot's word is moved into the shifter, which gives one pulse per slot. A word written with `tx_wr` after such a pulse is sent in the next slot.
- R7: If no word has been written since the previous slot load, the slot sends 0x0000 and `tx_underrun` is set. The flag stays set until `err_clr` is pulsed.
- R8: `rx_frame` and `tx_frame` each pulse once per accepted frame start of an enabled direction.
- R9: A frame pulse inside a frame does not restart the frame and raises no frame event. It sets `sync_err`, which stays set until `err_clr` is pulsed.
- R10: A frame pulse during the final data bit of a frame starts the next frame directly, with no error.
- R11: Frames that arrive while the receiver is disabled change neither `rx_data` nor the request count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bclk | input | 1 | Bit clock from the external master |
| fsync | input | 1 | Active-high frame pulse from the external master |
| din | input | 1 | Serial receive data |
| rx_en | input | 1 | Receiver enable; low holds the receiver in reset |
| tx_en | input | 1 | Transmitter enable; low holds the transmitter in reset |
| err_clr | input | 1 | Clears the sticky sync-error and underrun flags |
| tx_wr | input | 1 | Write strobe for the transmit holding register |
| tx_wdata | input | WORD_W | Transmit word |
| dout | output | 1 | Serial transmit data |
| rx_data | output | RX_REG_W | Last received word, right-justified and zero-filled |
| rx_req | output | 1 | One-cycle strobe per received word |
| tx_req | output | 1 | One-cycle strobe per transmit slot load |
| rx_frame | output | 1 | Receive frame-start event |
| tx_frame | output | 1 | Transmit frame-start event |
| sync_err | output | 1 | Sticky mid-frame sync error |
| tx_underrun | output | 1 | Sticky transmit underrun |

## Verification
Each bit-clock edge reaches the logic `SYNC_STAGES` clocks after the pin changes, plus one clock for edge detection. A receive strobe or frame event therefore follows the falling edge by about four system clocks, and a new `dout` bit follows the rising edge by about four clocks. The bench holds each bit-clock level for eight system clocks. It changes inputs on the falling system-clock edge and reads `dout` just before the next bit-clock rise. At that point the launched bit has been stable for several clocks. A monitor compares receive strobes against a queue of expected words as they occur. Flags, event counts and queue emptiness are checked only after idle bit periods, once every delayed result has settled.

// File: rtl/tdm_port_pkg.sv
package tdm_port_pkg;

  // Per-tick slot events produced by the frame tracker
  typedef struct packed {
    logic frame_start;  // accepted frame pulse, next bit is word 0 bit 0
    logic data_bit;     // this tick falls inside a data bit
    logic word_end;     // this tick is the last bit of a word
    logic frame_end;    // this tick is the last bit of the frame
    logic sync_err;     // frame pulse seen inside a frame, ignored
  } slot_evt_t;

endpackage

// File: rtl/tdm_in_sync.sv
module tdm_in_sync #(
  parameter int STAGES = 2,
  parameter int W      = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] sync_o
);

  logic [W-1:0] stg_q [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stg_q[0] <= '0;
          else        stg_q[0] <= async_i;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stg_q[s] <= '0;
          else        stg_q[s] <= stg_q[s-1];
        end
      end
    end
  endgenerate

  assign sync_o = stg_q[STAGES-1];

endmodule

// File: rtl/tdm_slot_framer.sv
module tdm_slot_framer
  import tdm_port_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int NUM_CH = 4
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      en,
  input  logic      tick,   // bit-clock falling edge
  input  logic      fs,
  output slot_evt_t evt
);

  localparam int BIT_W = (WORD_W > 1) ? $clog2(WORD_W) : 1;
  localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
  localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(WORD_W - 1);
  localparam logic [CH_W-1:0]  CH_LAST  = CH_W'(NUM_CH - 1);

  logic             active_q, active_d;
  logic             fs_prev_q, fs_prev_d;
  logic [BIT_W-1:0] bit_q, bit_d;
  logic [CH_W-1:0]  word_q, word_d;

  logic start, last_bit, last_word;

  assign start     = fs & ~fs_prev_q;
  assign last_bit  = (bit_q == BIT_LAST);
  assign last_word = (word_q == CH_LAST);

  always_comb begin
    active_d  = active_q;
    fs_prev_d = fs_prev_q;
    bit_d     = bit_q;
    word_d    = word_q;
    evt       = '0;
    if (tick) fs_prev_d = fs;
    if (!en) begin
      active_d = 1'b0;
      bit_d    = '0;
      word_d   = '0;
    end else if (tick) begin
      if (!active_q) begin
        if (start) begin
          active_d        = 1'b1;
          bit_d           = '0;
          word_d          = '0;
          evt.frame_start = 1'b1;
        end
      end else begin
        evt.data_bit  = 1'b1;
        evt.word_end  = last_bit;
        evt.frame_end = last_bit & last_word;
        if (last_bit && last_word) begin
          bit_d  = '0;
          word_d = '0;
          if (start) evt.frame_start = 1'b1;
          else       active_d        = 1'b0;
        end else begin
          evt.sync_err = start;
          if (last_bit) begin
            bit_d  = '0;
            word_d = word_q + 1'b1;
          end else begin
            bit_d  = bit_q + 1'b1;
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q  <= 1'b0;
      fs_prev_q <= 1'b0;
      bit_q     <= '0;
      word_q    <= '0;
    end else begin
      active_q  <= active_d;
      fs_prev_q <= fs_prev_d;
      bit_q     <= bit_d;
      word_q    <= word_d;
    end
  end

  // R9: a mid-frame pulse leaves the frame running
  a_r9_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    evt.sync_err |=> active_q);

  // R10: a pulse on the final bit reopens the frame at word 0 bit 0
  a_r10_back_to_back: assert property (@(posedge clk) disable iff (!rst_n)
    (evt.frame_end && evt.frame_start) |=> (active_q && bit_q == '0 && word_q == '0));

endmodule

// File: rtl/tdm_rx_path.sv
module tdm_rx_path
  import tdm_port_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int NUM_CH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              fall,
  input  logic              fs,
  input  logic              sdin,
  output logic [WORD_W-1:0] word,
  output logic              req,
  output logic              frame_evt,
  output logic              serr
);

  slot_evt_t evt;

  tdm_slot_framer #(.WORD_W(WORD_W), .NUM_CH(NUM_CH)) u_framer (
    .clk  (clk),
    .rst_n(rst_n),
    .en   (en),
    .tick (fall),
    .fs   (fs),
    .evt  (evt)
  );

  logic [WORD_W-1:0] sreg_q, sreg_d;
  logic [WORD_W-1:0] word_q, word_d;
  logic              req_q, frm_q;
  logic [WORD_W-1:0] shifted;

  assign shifted = {sreg_q[WORD_W-2:0], sdin};

  always_comb begin
    sreg_d = sreg_q;
    word_d = word_q;
    if (!en)               sreg_d = '0;
    else if (evt.data_bit) sreg_d = shifted;
    if (evt.word_end)      word_d = shifted;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sreg_q <= '0;
      word_q <= '0;
      req_q  <= 1'b0;
      frm_q  <= 1'b0;
    end else begin
      sreg_q <= sreg_d;
      word_q <= word_d;
      req_q  <= evt.word_end;
      frm_q  <= evt.frame_start;
    end
  end

  assign word      = word_q;
  assign req       = req_q;
  assign frame_evt = frm_q;
  assign serr      = evt.sync_err;

  // R4: request strobes are single-cycle
  a_r4_req_single: assert property (@(posedge clk) disable iff (!rst_n)
    req |=> !req);

  // R4: the final word of a frame is always delivered
  a_r4_frame_last_req: assert property (@(posedge clk) disable iff (!rst_n)
    evt.frame_end |=> req);

  // R1: a disabled receiver raises no request
  a_r1_rx_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !req);

endmodule

// File: rtl/tdm_tx_path.sv
module tdm_tx_path
  import tdm_port_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int NUM_CH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              fall,
  input  logic              rise,
  input  logic              fs,
  input  logic              wr,
  input  logic [WORD_W-1:0] wdata,
  input  logic              err_clr,
  output logic              sdout,
  output logic              req,
  output logic              frame_evt,
  output logic              serr,
  output logic              underrun
);

  slot_evt_t evt;

  tdm_slot_framer #(.WORD_W(WORD_W), .NUM_CH(NUM_CH)) u_framer (
    .clk  (clk),
    .rst_n(rst_n),
    .en   (en),
    .tick (fall),
    .fs   (fs),
    .evt  (evt)
  );

  logic [WORD_W-1:0] hold_q, hold_d;
  logic [WORD_W-1:0] sreg_q, sreg_d;
  logic              full_q, full_d;
  logic              drive_q, drive_d;
  logic              ld_q, ld_d;
  logic              sh_q, sh_d;
  logic              stop_q, stop_d;
  logic              req_d, req_q;
  logic              frm_q;
  logic              urun_q, urun_set;

  always_comb begin
    hold_d   = hold_q;
    sreg_d   = sreg_q;
    full_d   = full_q;
    drive_d  = drive_q;
    ld_d     = ld_q;
    sh_d     = sh_q;
    stop_d   = stop_q;
    req_d    = 1'b0;
    urun_set = 1'b0;
    if (!en) begin
      hold_d  = '0;
      sreg_d  = '0;
      full_d  = 1'b0;
      drive_d = 1'b0;
      ld_d    = 1'b0;
      sh_d    = 1'b0;
      stop_d  = 1'b0;
    end else begin
      // decisions taken on the falling edge, carried out on the next rise
      if (evt.frame_start || (evt.word_end && !evt.frame_end)) ld_d   = 1'b1;
      else if (evt.frame_end)                                  stop_d = 1'b1;
      else if (evt.data_bit)                                   sh_d   = 1'b1;
      if (rise) begin
        if (ld_q) begin
          sreg_d   = full_q ? hold_q : '0;
          urun_set = ~full_q;
          full_d   = 1'b0;
          drive_d  = 1'b1;
          req_d    = 1'b1;
          ld_d     = 1'b0;
        end else if (sh_q) begin
          sreg_d = {sreg_q[WORD_W-2:0], 1'b0};
          sh_d   = 1'b0;
        end else if (stop_q) begin
          drive_d = 1'b0;
          stop_d  = 1'b0;
        end
      end
      if (wr) begin
        hold_d = wdata;
        full_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q  <= '0;
      sreg_q  <= '0;
      full_q  <= 1'b0;
      drive_q <= 1'b0;
      ld_q    <= 1'b0;
      sh_q    <= 1'b0;
      stop_q  <= 1'b0;
      req_q   <= 1'b0;
      frm_q   <= 1'b0;
      urun_q  <= 1'b0;
    end else begin
      hold_q  <= hold_d;
      sreg_q  <= sreg_d;
      full_q  <= full_d;
      drive_q <= drive_d;
      ld_q    <= ld_d;
      sh_q    <= sh_d;
      stop_q  <= stop_d;
      req_q   <= req_d;
      frm_q   <= evt.frame_start;
      urun_q  <= (urun_q & ~err_clr) | urun_set;
    end
  end

  assign sdout     = drive_q & sreg_q[WORD_W-1];
  assign req       = req_q;
  assign frame_evt = frm_q;
  assign serr      = evt.sync_err;
  assign underrun  = urun_q;

  // R1: a disabled transmitter holds its output low
  a_r1_tx_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !sdout);

  // R6: one load strobe per slot, never two in a row
  a_r6_req_single: assert property (@(posedge clk) disable iff (!rst_n)
    req |=> !req);

  // R7: underrun flag holds until cleared
  a_r7_underrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (underrun && !err_clr) |=> underrun);

endmodule

// File: rtl/tdm_slave_port.sv
module tdm_slave_port #(
  parameter int WORD_W      = 16,
  parameter int NUM_CH      = 4,
  parameter int RX_REG_W    = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bclk,
  input  logic                fsync,
  input  logic                din,
  input  logic                rx_en,
  input  logic                tx_en,
  input  logic                err_clr,
  input  logic                tx_wr,
  input  logic [WORD_W-1:0]   tx_wdata,
  output logic                dout,
  output logic [RX_REG_W-1:0] rx_data,
  output logic                rx_req,
  output logic                tx_req,
  output logic                rx_frame,
  output logic                tx_frame,
  output logic                sync_err,
  output logic                tx_underrun
);

  localparam int PAD_W = RX_REG_W - WORD_W;

  logic [2:0] pins_s;
  logic       bclk_s, fs_s, din_s;
  logic       bclk_prev_q;
  logic       bit_rise, bit_fall;

  tdm_in_sync #(.STAGES(SYNC_STAGES), .W(3)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .async_i({bclk, fsync, din}),
    .sync_o (pins_s)
  );

  assign {bclk_s, fs_s, din_s} = pins_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bclk_prev_q <= 1'b0;
    else        bclk_prev_q <= bclk_s;
  end

  assign bit_rise = bclk_s & ~bclk_prev_q;
  assign bit_fall = ~bclk_s & bclk_prev_q;

  logic [WORD_W-1:0] rx_word;
  logic              rx_serr, tx_serr;

  tdm_rx_path #(.WORD_W(WORD_W), .NUM_CH(NUM_CH)) u_rx (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (rx_en),
    .fall     (bit_fall),
    .fs       (fs_s),
    .sdin     (din_s),
    .word     (rx_word),
    .req      (rx_req),
    .frame_evt(rx_frame),
    .serr     (rx_serr)
  );

  tdm_tx_path #(.WORD_W(WORD_W), .NUM_CH(NUM_CH)) u_tx (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (tx_en),
    .fall     (bit_fall),
    .rise     (bit_rise),
    .fs       (fs_s),
    .wr       (tx_wr),
    .wdata    (tx_wdata),
    .err_clr  (err_clr),
    .sdout    (dout),
    .req      (tx_req),
    .frame_evt(tx_frame),
    .serr     (tx_serr),
    .underrun (tx_underrun)
  );

  generate
    if (PAD_W > 0) begin : g_pad
      assign rx_data = {{PAD_W{1'b0}}, rx_word};
    end else begin : g_nopad
      assign rx_data = rx_word[RX_REG_W-1:0];
    end
  endgenerate

  logic serr_q, serr_d;

  always_comb begin
    serr_d = serr_q;
    if (err_clr)           serr_d = 1'b0;
    if (rx_serr | tx_serr) serr_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) serr_q <= 1'b0;
    else        serr_q <= serr_d;
  end

  assign sync_err = serr_q;

  // R9: sync error holds until cleared
  a_r9_sync_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_err && !err_clr) |=> sync_err);

  // R8: frame events never repeat on consecutive clocks
  a_r8_frame_single: assert property (@(posedge clk) disable iff (!rst_n)
    rx_frame |=> !rx_frame);

endmodule

// File: tb/tdm_slave_port_test.sv
`timescale 1ns/1ps
module tdm_slave_port_test;

  localparam int WW = 16;
  localparam int NC = 4;
  localparam int RW = 32;
  localparam int HALF = 8;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, bclk, fsync, din, rx_en, tx_en, err_clr, tx_wr;
  logic [WW-1:0] tx_wdata;
  logic dout, rx_req, tx_req, rx_frame, tx_frame, sync_err, tx_underrun;
  logic [RW-1:0] rx_data;

  tdm_slave_port #(.WORD_W(WW), .NUM_CH(NC), .RX_REG_W(RW), .SYNC_STAGES(2)) uut (
    .clk(clk), .rst_n(rst_n), .bclk(bclk), .fsync(fsync), .din(din),
    .rx_en(rx_en), .tx_en(tx_en), .err_clr(err_clr), .tx_wr(tx_wr),
    .tx_wdata(tx_wdata), .dout(dout), .rx_data(rx_data), .rx_req(rx_req),
    .tx_req(tx_req), .rx_frame(rx_frame), .tx_frame(tx_frame),
    .sync_err(sync_err), .tx_underrun(tx_underrun)
  );

  int checks = 0, errors = 0;
  int mon_checks = 0, mon_errors = 0;
  int rx_frm_cnt = 0, tx_frm_cnt = 0, txreq_cnt = 0;

  logic [RW-1:0] rx_q [$];
  logic [WW-1:0] tx_q [$];
  logic [WW-1:0] tx_src [$];
  logic [WW-1:0] fw [NC];
  logic [WW-1:0] txw;
  int txn = 0;
  bit prev_data = 0, chk_idle = 0, rx_on = 0, tx_on = 0, kick = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // receive scoreboard monitor (R2, R3, R4)
  always @(negedge clk) begin
    if (rst_n) begin
      if (rx_frame) rx_frm_cnt++;
      if (tx_frame) tx_frm_cnt++;
      if (rx_req) begin
        mon_checks++;
        if (rx_q.size() == 0) begin
          mon_errors++;
          $display("FAIL R4 unexpected rx_req: actual %h expected none", rx_data);
        end else begin
          logic [RW-1:0] e;
          e = rx_q.pop_front();
          if (rx_data !== e) begin
            mon_errors++;
            $display("FAIL R2/R3 rx word: actual %h expected %h", rx_data, e);
          end
        end
      end
    end
  end

  // transmit word supplier (R6)
  always @(negedge clk) begin
    tx_wr = 1'b0;
    if (rst_n && tx_req) txreq_cnt++;
    if (rst_n && (tx_req || kick) && tx_src.size() > 0) begin
      tx_wdata = tx_src.pop_front();
      tx_wr    = 1'b1;
    end
  end

  task automatic bit_period(input logic f, input logic d, input bit is_data);
    if (prev_data) begin
      txw = {txw[WW-2:0], dout};
      txn++;
      if (txn == WW) begin
        logic [WW-1:0] e;
        txn = 0;
        if (tx_q.size() == 0) e = 'x; else e = tx_q.pop_front();
        check(txw === e, "R5", "tx word", {16'h0, txw}, {16'h0, e});
      end
    end
    if (chk_idle) check(dout === 1'b0, "R1", "dout idle", {31'h0, dout}, 32'h0);
    prev_data = is_data && tx_on;
    fsync = f; din = d; bclk = 1'b1;
    repeat (HALF) @(negedge clk);
    bclk = 1'b0;
    repeat (HALF) @(negedge clk);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) bit_period(1'b0, 1'b0, 1'b0);
  endtask

  task automatic run_frame(input bit lead, input bit tail, input int glitch);
    if (rx_on) for (int c = 0; c < NC; c++) rx_q.push_back({16'h0, fw[c]});
    if (lead) bit_period(1'b1, 1'b0, 1'b0);
    for (int c = 0; c < NC; c++)
      for (int b = 0; b < WW; b++) begin
        int idx;
        idx = c * WW + b;
        bit_period((tail && idx == NC*WW-1) || idx == glitch, fw[c][WW-1-b], 1'b1);
      end
  endtask

  task automatic pulse_clr();
    err_clr = 1'b1; @(negedge clk); err_clr = 1'b0; @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors",
             checks + mon_checks + 1, errors + mon_errors + 1);
    $finish;
  end

  initial begin
    logic [RW-1:0] held;
    rst_n = 0; bclk = 0; fsync = 0; din = 0; rx_en = 0; tx_en = 0;
    err_clr = 0; tx_wdata = '0;
    repeat (5) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    check(dout === 0 && rx_req === 0 && tx_req === 0, "R1", "reset strobes", {29'h0, dout, rx_req, tx_req}, 0);
    check(rx_data === 0 && sync_err === 0 && tx_underrun === 0, "R1", "reset state", rx_data, 0);

    // both directions disabled: nothing happens
    fw = '{16'h1234, 16'h5678, 16'h9ABC, 16'hDEF0};
    chk_idle = 1;
    run_frame(1, 0, -1);
    idle(3);
    chk_idle = 0;
    check(rx_frm_cnt == 0 && tx_frm_cnt == 0, "R1", "events while disabled", rx_frm_cnt + tx_frm_cnt, 0);

    // enable and load transmit words
    rx_en = 1; tx_en = 1; rx_on = 1; tx_on = 1;
    for (int k = 0; k < 4*NC; k++) begin
      logic [WW-1:0] w;
      w = 16'hA5C3 ^ WW'(k * 16'h1357);
      tx_q.push_back(w);
      if (k > 0) tx_src.push_back(w);
      else begin
        tx_src.push_back(w);
      end
    end
    for (int k = 0; k < NC; k++) tx_q.push_back(16'h0000);
    @(negedge clk); kick = 1; @(negedge clk); kick = 0;
    repeat (2) @(negedge clk);

    // frame A runs directly into frame B (R10)
    fw = '{16'hFFFF, 16'h8001, 16'h0000, 16'h5A3C};
    run_frame(1, 1, -1);
    fw = '{16'h0F0F, 16'hC003, 16'h7FFE, 16'h1357};
    run_frame(0, 0, -1);
    idle(4);
    check(rx_q.size() == 0, "R4", "rx words delivered", rx_q.size(), 0);
    check(sync_err === 0, "R10", "no error on back-to-back", {31'h0, sync_err}, 0);
    check(rx_frm_cnt == 2 && tx_frm_cnt == 2, "R8", "frame events", rx_frm_cnt*16 + tx_frm_cnt, 34);
    check(rx_data === 32'h0000_1357, "R3", "zero-filled last word", rx_data, 32'h0000_1357);

    // frame C with a stray frame pulse at bit 20 (R9)
    fw = '{16'h2468, 16'hACE0, 16'h1111, 16'hEEEE};
    run_frame(1, 0, 20);
    idle(4);
    check(sync_err === 1, "R9", "sync error set", {31'h0, sync_err}, 1);
    check(rx_frm_cnt == 3, "R9", "no extra frame event", rx_frm_cnt, 3);
    check(rx_q.size() == 0, "R9", "frame not restarted", rx_q.size(), 0);
    pulse_clr();
    check(sync_err === 0, "R9", "sync error cleared", {31'h0, sync_err}, 0);

    // frame D with receiver disabled (R11)
    rx_en = 0; rx_on = 0;
    idle(2);
    held = rx_data;
    fw = '{16'hBEEF, 16'hCAFE, 16'hF00D, 16'h0BAD};
    run_frame(1, 0, -1);
    idle(4);
    check(rx_data === held, "R11", "rx_data unchanged", rx_data, held);
    check(rx_frm_cnt == 3, "R11", "no rx event", rx_frm_cnt, 3);
    check(tx_underrun === 0, "R7", "no underrun yet", {31'h0, tx_underrun}, 0);
    rx_en = 1; rx_on = 1;
    idle(2);

    // frame E: transmit supply exhausted (R7)
    fw = '{16'h8000, 16'h0001, 16'h4321, 16'hFEDC};
    run_frame(1, 0, -1);
    idle(4);
    check(tx_underrun === 1, "R7", "underrun set", {31'h0, tx_underrun}, 1);
    check(tx_q.size() == 0, "R5", "tx words all sent", tx_q.size(), 0);
    check(txreq_cnt == 5*NC, "R6", "tx_req per slot", txreq_cnt, 5*NC);
    pulse_clr();
    check(tx_underrun === 0, "R7", "underrun cleared", {31'h0, tx_underrun}, 0);

    // frame F with transmitter disabled (R1)
    tx_en = 0; tx_on = 0;
    idle(2);
    chk_idle = 1;
    fw = '{16'h3C3C, 16'hC3C3, 16'h00FF, 16'hFF00};
    run_frame(1, 0, -1);
    idle(3);
    chk_idle = 0;
    check(tx_frm_cnt == 5, "R1", "no tx event while disabled", tx_frm_cnt, 5);
    check(rx_frm_cnt == 5, "R8", "rx events", rx_frm_cnt, 5);
    check(rx_q.size() == 0, "R4", "final rx words", rx_q.size(), 0);

    $display("Simulation finished: %0d checks, %0d errors",
             checks + mon_checks, errors + mon_errors);
    $finish;
  end

endmodule